// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits in the read path of a non-volatile byte store. While an internal programming or erase cycle is running, reads should not return array contents. They return a status word that lets the host poll for completion. The write sequencer supplies two inputs: a busy flag and the byte most recently presented for writing. Status is not held in a separate register. It is folded into every ordinary read that is accepted while busy is high.

During busy, the returned word carries three things. The top data bit is the complement of the top bit of the pending byte. The bit below it flips on every accepted read. The remaining low bits echo the pending byte. The same status applies when a write was rejected by protection but the internal timer still runs; in that case the pending byte is the attempted data. When busy is low, reads return the array data unchanged.

An access is accepted only when the read strobe is high and both the select and output-enable inputs are high. The result appears one clock later with a valid flag. Outside accepted accesses the valid flag is low, which stands in for a high-impedance bus.

Top module: `wr_status_resp`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is 0.
- R2: `rd_valid` is 1 in the cycle after a clock edge where `rd_req`, `sel` and `oe_en` were all 1. In every other cycle it is 0.
- R3: An accepted read sampled while `busy` is 0 returns `arr_data` as sampled at that edge.
- R4: An accepted read sampled while `busy` is 1 returns the complement of `last_data[7]` on `rd_data[7]`.
- R5: An accepted read sampled while `busy` is 1 returns `last_data[5:0]` on `rd_data[5:0]`.
- R6: On `rd_data[6]`, the first accepted read of a busy cycle returns 1. Each further accepted read in that cycle returns the opposite of the previous one.
- R7: A read strobe without both enables returns no data and does not advance the toggle sequence of R6.
- R8: A read accepted at the edge where `busy` is already 0 returns `arr_data`, even immediately after a busy cycle ends.
- R9: A new busy cycle restarts the toggle sequence at 1, whatever value the previous cycle left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Internal program/erase cycle running |
| last_data | input | DW | Byte most recently presented for writing |
| arr_data | input | DW | Array read data for the current address |
| rd_req | input | 1 | Read strobe, one cycle per access |
| sel | input | 1 | Device select, active high |
| oe_en | input | 1 | Output enable, active high |
| rd_data | output | DW | Returned read word, held between accesses |
| rd_valid | output | 1 | Read data driven this cycle |

## Verification
Idle reads use two complementary array patterns to show that data passes straight through when busy is low. Busy reads use pending bytes whose top bit is 0 and then 1, with differing low bits. This separates the complemented top bit from the echoed low bits. Sequences of three or more status reads show the bit-6 alternation. Strobes with one enable missing are placed between status reads, and they must leave that alternation undisturbed. Reads at the edge where busy falls, and at the start of a new cycle that follows an odd read count, show the clean switch to array data and the reseeding of the toggle.

// File: rtl/wr_status_resp.sv
module wr_status_resp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [DW-1:0] last_data,
  input  logic [DW-1:0] arr_data,
  input  logic          rd_req,
  input  logic          sel,
  input  logic          oe_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int PB = DW - 1;
  localparam int TB = DW - 2;

  logic          busy_q;
  logic          tog;
  logic          tog_now;
  logic          acc;
  logic          cyc_start;
  logic [DW-1:0] stat_word;

  assign acc       = rd_req & sel & oe_en;
  assign cyc_start = busy & ~busy_q;
  assign tog_now   = cyc_start ? 1'b1 : tog;

  always_comb begin
    stat_word     = last_data;
    stat_word[PB] = ~last_data[PB];
    stat_word[TB] = tog_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      tog      <= 1'b1;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      busy_q   <= busy;
      rd_valid <= acc;
      if (acc) rd_data <= busy ? stat_word : arr_data;
      if (busy && acc) tog <= ~tog_now;
      else if (cyc_start) tog <= 1'b1;
    end
  end

  assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rd_valid);
  assert_novalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rd_valid);
  assert_idle_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !busy) |=> rd_data == $past(arr_data));
  assert_poll_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && busy) |=> rd_data[PB] == !$past(last_data[PB]));
  assert_low_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && busy) |=> rd_data[TB-1:0] == $past(last_data[TB-1:0]));
  assert_first_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && busy && !busy_q) |=> rd_data[TB]);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(rd_data));
endmodule

// File: tb/sim_wr_status_resp.sv
module sim_wr_status_resp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0;
  logic [7:0] last_data = 8'h00;
  logic [7:0] arr_data = 8'h00;
  logic       rd_req = 1'b0;
  logic       sel = 1'b0;
  logic       oe_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wr_status_resp #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .busy(busy), .last_data(last_data),
    .arr_data(arr_data), .rd_req(rd_req), .sel(sel), .oe_en(oe_en),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(string req, logic [8:0] got, logic [8:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input bit s, input bit o, string req, input bit ev, input logic [7:0] ed);
    @(negedge clk);
    rd_req = 1'b1; sel = s; oe_en = o;
    @(negedge clk);
    rd_req = 1'b0; sel = 1'b0; oe_en = 1'b0;
    if (ev) chk(req, {rd_valid, rd_data}, {1'b1, ed});
    else    chk(req, {8'h00, rd_valid}, 9'h000);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", {rd_valid, rd_data}, 9'h000);
    rst_n = 1'b1;
  endtask

  task automatic t_idle();
    arr_data = 8'hA5; rd(1, 1, "R3", 1, 8'hA5);
    arr_data = 8'h5A; rd(1, 1, "R3", 1, 8'h5A);
    rd(0, 1, "R2", 0, 8'h00);
    rd(1, 0, "R2", 0, 8'h00);
  endtask

  task automatic t_poll();
    @(negedge clk);
    busy = 1'b1; last_data = 8'h1A; arr_data = 8'h00;
    rd(1, 1, "R4 R5 R6", 1, 8'hDA);
    rd(1, 0, "R7", 0, 8'h00);
    rd(1, 1, "R6 R7", 1, 8'h9A);
    rd(0, 1, "R7", 0, 8'h00);
    rd(1, 1, "R6 R7", 1, 8'hDA);
    last_data = 8'hC3;
    rd(1, 1, "R4 R5", 1, 8'h03);
  endtask

  task automatic t_end();
    @(negedge clk);
    busy = 1'b0; last_data = 8'h00; arr_data = 8'h3C; rd_req = 1'b1; sel = 1'b1; oe_en = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; sel = 1'b0; oe_en = 1'b0;
    chk("R8", {rd_valid, rd_data}, {1'b1, 8'h3C});
    arr_data = 8'hC3; rd(1, 1, "R8", 1, 8'hC3);
  endtask

  task automatic t_restart();
    @(negedge clk);
    busy = 1'b1; last_data = 8'h85;
    repeat (3) @(negedge clk);
    rd(1, 1, "R6", 1, 8'h45);
    @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
    busy = 1'b1; last_data = 8'h07; rd_req = 1'b1; sel = 1'b1; oe_en = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; sel = 1'b0; oe_en = 1'b0;
    chk("R9", {rd_valid, rd_data}, {1'b1, 8'hC7});
    rd(1, 1, "R9", 1, 8'h87);
    @(negedge clk);
    busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_poll();
    t_end();
    t_restart();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule